// File: doc/BRIEF.md
# Usage-Counter Way Replacement

This block tracks recent use of each way in every set of a set-associative cache and names the way to replace on a miss. Each way of each set holds a small usage counter that saturates at zero. A hit lifts the hit way to the top value and lowers only the ways that ranked above it. A refill after a miss ages every nonzero counter in the set and lifts the refilled way to the top value.

The cache controller presents a set index every cycle. It reads the victim way combinationally for that set and then strobes one of three updates: a hit with its way number, a refill completion, or an invalidate with a per-way mask. The number of usage states is a parameter from 2 to 4. The counters of the addressed set are brought out so their state can be seen. Tag storage, data storage and refill sequencing belong to the surrounding cache.

Top module: `usage_repl`

## Requirements
- R1: After reset every counter of every set is zero and the victim of every set is way 0.
- R2: USTATES may be 2, 3 or 4. Counters are 1 bit wide for 2 states and 2 bits wide otherwise. The top value is USTATES-1 and no counter ever exceeds it. The counter of way w appears at `set_counts[w*CNT_W +: CNT_W]` for the set on `set_idx`.
- R3: `victim_way` is the lowest-numbered way whose counter is the smallest value below the top. If no counter is below the top it is way 0. It follows `set_idx` combinationally.
- R4: On `hit_valid`, every way whose counter is strictly greater than the hit way's counter drops by one, and the hit way's counter becomes the top value.
- R5: On `fill_valid` without `hit_valid`, every nonzero counter in the set drops by one. The way shown on `victim_way` in that cycle then becomes the top value.
- R6: On `inv_valid`, each way whose `inv_mask` bit is 1 has its counter forced to zero. This is applied after any hit or fill update in the same cycle, so the zero wins.
- R7: When `hit_valid` and `fill_valid` are both high, only the hit update of R4 takes place.
- R8: An update changes only the set on `set_idx`. With no strobe high, no counter changes.
- R9: An update strobed in one cycle is visible on `set_counts` and `victim_way` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | SET_W | Set addressed by lookup and update |
| hit_valid | input | 1 | Hit update strobe |
| hit_way | input | WAY_W | Way that hit |
| fill_valid | input | 1 | Refill-complete strobe, victim update |
| inv_valid | input | 1 | Invalidate strobe |
| inv_mask | input | NUM_WAYS | Ways to invalidate |
| victim_way | output | WAY_W | Way to replace in the addressed set |
| set_counts | output | NUM_WAYS*CNT_W | Counters of the addressed set |

## Verification
The tie rule in the victim choice only matters once several ways share the smallest counter below the top. From reset a run of refills walks the victim through each way in turn, so the counters become a staircase. Hits on a middle way then create equal low values, and an invalidate of two ways makes two zero counters where the lower one must win. Each set is changed while another set holds a known pattern, and that set is read back afterwards to show it was not touched.

// File: rtl/usage_repl.sv
module usage_repl #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 4,
  parameter int USTATES  = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int CNT_W = (USTATES > 2) ? 2 : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SET_W-1:0]          set_idx,
  input  logic                      hit_valid,
  input  logic [WAY_W-1:0]          hit_way,
  input  logic                      fill_valid,
  input  logic                      inv_valid,
  input  logic [NUM_WAYS-1:0]       inv_mask,
  output logic [WAY_W-1:0]          victim_way,
  output logic [NUM_WAYS*CNT_W-1:0] set_counts
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(USTATES - 1);

  logic [NUM_WAYS-1:0][CNT_W-1:0] cnt [NUM_SETS];
  logic [NUM_WAYS-1:0][CNT_W-1:0] row, nxt;
  logic [CNT_W-1:0]               best;

  assign row        = cnt[set_idx];
  assign set_counts = row;

  always_comb begin
    victim_way = '0;
    best       = TOP;
    for (int w = 0; w < NUM_WAYS; w++)
      if (row[w] < best) begin
        best       = row[w];
        victim_way = WAY_W'(w);
      end
  end

  always_comb begin
    nxt = row;
    if (hit_valid) begin
      for (int w = 0; w < NUM_WAYS; w++)
        if (row[w] > row[hit_way]) nxt[w] = row[w] - 1'b1;
      nxt[hit_way] = TOP;
    end else if (fill_valid) begin
      for (int w = 0; w < NUM_WAYS; w++)
        if (row[w] != '0) nxt[w] = row[w] - 1'b1;
      nxt[victim_way] = TOP;
    end
    if (inv_valid)
      for (int w = 0; w < NUM_WAYS; w++)
        if (inv_mask[w]) nxt[w] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) cnt[s] <= '0;
    end else if (hit_valid || fill_valid || inv_valid) begin
      cnt[set_idx] <= nxt;
    end
  end
endmodule

module usage_repl_chk #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 4,
  parameter int USTATES  = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int CNT_W = (USTATES > 2) ? 2 : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SET_W-1:0]          set_idx,
  input logic                      hit_valid,
  input logic [WAY_W-1:0]          hit_way,
  input logic                      fill_valid,
  input logic                      inv_valid,
  input logic [NUM_WAYS-1:0]       inv_mask,
  input logic [WAY_W-1:0]          victim_way,
  input logic [NUM_WAYS*CNT_W-1:0] set_counts
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(USTATES - 1);

  always_ff @(negedge clk) begin
    if (rst_n) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        // R2
        counter_range_chk: assert (set_counts[w*CNT_W +: CNT_W] <= TOP);
        // R3
        victim_min_chk: assert (set_counts[victim_way*CNT_W +: CNT_W] <= set_counts[w*CNT_W +: CNT_W]);
      end
    end
  end

  // R4
  hit_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && !inv_valid |=> (set_idx != $past(set_idx)) ||
      (set_counts[$past(hit_way)*CNT_W +: CNT_W] == TOP));

  // R5
  fill_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !hit_valid && !inv_valid |=> (set_idx != $past(set_idx)) ||
      (set_counts[$past(victim_way)*CNT_W +: CNT_W] == TOP));

  // R6
  inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_mask[0] |=> (set_idx != $past(set_idx)) ||
      (set_counts[CNT_W-1:0] == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid && !fill_valid && !inv_valid |=> (set_idx != $past(set_idx)) ||
      $stable(set_counts));
endmodule

bind usage_repl usage_repl_chk #(
  .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .USTATES(USTATES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_valid(hit_valid),
  .hit_way(hit_way), .fill_valid(fill_valid), .inv_valid(inv_valid),
  .inv_mask(inv_mask), .victim_way(victim_way), .set_counts(set_counts)
);

// File: tb/usage_repl_tb.sv
module usage_repl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] set_idx = 0;
  logic       hit_valid = 0, fill_valid = 0, inv_valid = 0;
  logic [1:0] hit_way = 0;
  logic [3:0] inv_mask = 0;
  logic [1:0] victim_way, victim2;
  logic [7:0] set_counts;
  logic [3:0] counts2;
  int checks = 0, failures = 0;
  int model [4][4];

  always #5 clk = ~clk;

  usage_repl #(.NUM_SETS(4), .NUM_WAYS(4), .USTATES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_valid(hit_valid),
    .hit_way(hit_way), .fill_valid(fill_valid), .inv_valid(inv_valid),
    .inv_mask(inv_mask), .victim_way(victim_way), .set_counts(set_counts));

  usage_repl #(.NUM_SETS(4), .NUM_WAYS(4), .USTATES(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_valid(hit_valid),
    .hit_way(hit_way), .fill_valid(fill_valid), .inv_valid(inv_valid),
    .inv_mask(inv_mask), .victim_way(victim2), .set_counts(counts2));

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int ref_victim(int s);
    int v = 0, b = 3;
    for (int w = 0; w < 4; w++) if (model[s][w] < b) begin b = model[s][w]; v = w; end
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_set(string req, int s);
    set_idx = 2'(s);
    #1;
    for (int w = 0; w < 4; w++) check(req, int'(set_counts[w*2 +: 2]), model[s][w]);
    check(req, int'(victim_way), ref_victim(s));
  endtask

  task automatic pulse();
    @(negedge clk);
    hit_valid = 0; fill_valid = 0; inv_valid = 0; inv_mask = 0;
  endtask

  task automatic do_fill(int s);
    int v;
    set_idx = 2'(s); fill_valid = 1;
    v = ref_victim(s);
    for (int w = 0; w < 4; w++) if (model[s][w] > 0) model[s][w]--;
    model[s][v] = 3;
    pulse();
  endtask

  task automatic do_hit(int s, int hw);
    int h;
    set_idx = 2'(s); hit_valid = 1; hit_way = 2'(hw);
    h = model[s][hw];
    for (int w = 0; w < 4; w++) if (model[s][w] > h) model[s][w]--;
    model[s][hw] = 3;
    pulse();
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) model[s][w] = 0;
      check_set("R1", s);
    end
  endtask

  task automatic t_fill_walk();
    for (int i = 0; i < 4; i++) begin
      do_fill(1);
      check_set("R5", 1);
    end
    check("R5", int'(set_counts), 8'b11_10_01_00);
  endtask

  task automatic t_hits();
    do_hit(1, 2);
    check_set("R4", 1);
    do_hit(1, 0);
    check_set("R4", 1);
    check("R4", int'(set_counts), 8'b01_10_00_11);
    do_hit(1, 0);
    check_set("R4", 1);
  endtask

  task automatic t_tie_invalidate();
    set_idx = 1; inv_valid = 1; inv_mask = 4'b1010;
    model[1][1] = 0; model[1][3] = 0;
    pulse();
    check_set("R6", 1);
    check("R3", int'(victim_way), 1);
  endtask

  task automatic t_hit_over_fill_and_inv_wins();
    set_idx = 1; hit_valid = 1; fill_valid = 1; hit_way = 3;
    begin
      int h = model[1][3];
      for (int w = 0; w < 4; w++) if (model[1][w] > h) model[1][w]--;
      model[1][3] = 3;
    end
    pulse();
    check_set("R7", 1);
    set_idx = 1; hit_valid = 1; hit_way = 2; inv_valid = 1; inv_mask = 4'b0100;
    begin
      int h = model[1][2];
      for (int w = 0; w < 4; w++) if (model[1][w] > h) model[1][w]--;
      model[1][2] = 0;
    end
    pulse();
    check_set("R6", 1);
  endtask

  task automatic t_isolation();
    do_fill(2);
    do_hit(2, 3);
    check_set("R8", 2);
    for (int s = 0; s < 4; s++) check_set("R8", s);
    set_idx = 2;
    repeat (3) @(negedge clk);
    check_set("R8", 2);
  endtask

  task automatic t_timing();
    set_idx = 3; fill_valid = 1;
    @(posedge clk);
    #1;
    check("R9", int'(set_counts), 8'b00_00_00_11);
    @(negedge clk);
    fill_valid = 0;
    for (int w = 0; w < 4; w++) model[3][w] = 0;
    model[3][0] = 3;
    check_set("R9", 3);
  endtask

  task automatic t_two_states();
    set_idx = 0; #1;
    check("R2", int'(counts2), 0);
    set_idx = 0; fill_valid = 1; pulse();
    set_idx = 0; #1;
    check("R2", int'(counts2), 4'b0001);
    set_idx = 0; fill_valid = 1; pulse();
    set_idx = 0; #1;
    check("R2", int'(counts2), 4'b0010);
    check("R3", int'(victim2), 0);
    set_idx = 0; hit_valid = 1; hit_way = 2; pulse();
    set_idx = 0; #1;
    check("R2", int'(counts2), 4'b0100);
    check("R3", int'(victim2), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_walk();
    t_hits();
    t_tie_invalidate();
    t_hit_over_fill_and_inv_wins();
    t_isolation();
    t_timing();
    for (int w = 0; w < 4; w++) model[0][w] = 0;
    t_two_states();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule